// File: doc/BRIEF.md
# Cache-Side Line Flush Controller

This block is the per-line coherence engine of a private cache that takes part in a MOESI-style protocol. It adds a flush command to that protocol. A flush removes the line from every cache in the system and returns the latest copy to memory.

The controller first asks the directory for exclusive ownership with a dedicated exclusive-for-flush request (GETF). It then counts the acknowledgements from the other caches and from memory. The line is held in a side buffer rather than in the cache array. Once ownership is complete, the controller issues a flush write-back request (PUTF). When the directory acknowledges that request, the buffered data goes to memory.

Ordinary load and store miss handling lives elsewhere. While a flush is in flight, this block only stalls local requests and signals when they may be replayed. The stable state of the line is loaded through a fill port by the normal miss path.

Top module: `flush_line_ctrl`

## Requirements
- R1: After reset, `line_state` is Invalid (code 0) and every output valid, pulse and busy flag is low.
- R2: A flush (`loc_op` = 2) in Invalid does the following on the next edge: it clears the buffer's dirty and sharer flags, emits GETF (`dir_req_kind` = 0), and enters the invalid-to-flush state (code 8). It does not pulse `line_drop`.
- R3: A flush in a valid stable state does three things: it copies `line_data`/`line_dirty` into the buffer, pulses `line_drop`, and emits GETF. Shared (1) moves to code 9 and Owned (2) moves to code 10. Exclusive (3) and Modified (4) both move to code 12.
- R4: GETF loads the pending count with `NUM_CACHES` from Invalid or Shared, and with `NUM_CACHES-1` from Owned, Exclusive or Modified. Every response (ack = 0, shared data = 1, exclusive data = 2) taken in a flush state lowers the count by one. The count reaching zero is the only thing that starts the write-back, and this happens on the first idle cycle after it reaches zero.
- R5: In state 8, shared data moves to state 11 and exclusive data moves to state 13. Either kind of data is captured into the buffer with its dirty bit. In state 9, either kind of data moves to state 11 and ORs the dirty bit into the buffer.
- R6: When the count is zero, states 10 and 12 always emit PUTF (`dir_req_kind` = 1) and enter state 14. States 11 and 13 do so only if no ack with `rsp_shared` set has arrived since the flush began; otherwise they hold.
- R7: In state 12, a block ack (`fwd_kind` = 4) emits PUTF at once and enters state 14.
- R8: In state 14, a write-back ack (`fwd_kind` = 5) sends the buffered data and dirty flag on `mem_wb_*` and returns the line to Invalid.
- R9: Exclusive-request (0) and invalidate (3) forwards are handled as follows. In states 10 and 12 they return exclusive data from the buffer, raise the count by one, and move to state 8. In state 9 they return a plain ack and move to state 8. In state 8, these forwards and a shared-request forward (1) each return an ack.
- R10: While `line_state` bit 3 is set, `loc_busy` is high and a local request is parked. One cycle after the line is back in a stable state, `loc_replay` pulses once. Without a parked request it stays low.
- R11: `fill_valid` loads `fill_state` only while the line is stable; during a flush it has no effect on `line_state`.
- R12: In state 9, a shared-request forward gets an ack with no state change. In state 10, shared and merged shared requests (2) get shared data from the buffer and the state is kept. In state 12, a merged request gets shared data and moves to state 10, and a shared request behaves like an exclusive one (R9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_valid | input | 1 | Local request present |
| loc_op | input | 2 | Local operation: 0 load, 1 store, 2 flush |
| line_data | input | DATA_W | Current cache-array copy of the line |
| line_dirty | input | 1 | Dirty flag of the array copy |
| fill_valid | input | 1 | Normal path installs a stable state |
| fill_state | input | 3 | Stable state code 0..4 to install |
| fwd_valid | input | 1 | Forwarded request present |
| fwd_kind | input | 3 | 0 excl req, 1 shared req, 2 merged shared, 3 invalidate, 4 block ack, 5 write-back ack |
| rsp_valid | input | 1 | Response present |
| rsp_kind | input | 2 | 0 ack, 1 shared data, 2 exclusive data |
| rsp_data | input | DATA_W | Response data |
| rsp_dirty | input | 1 | Response dirty flag |
| rsp_shared | input | 1 | Ack reports a remaining sharer |
| dir_req_valid | output | 1 | Directory request pulse |
| dir_req_kind | output | 1 | 0 GETF, 1 PUTF |
| peer_rsp_valid | output | 1 | Response to a peer pulse |
| peer_rsp_kind | output | 2 | 0 ack, 1 shared data, 2 exclusive data |
| peer_rsp_data | output | DATA_W | Data sent to the peer |
| peer_rsp_dirty | output | 1 | Dirty flag sent to the peer |
| mem_wb_valid | output | 1 | Write-back to memory pulse |
| mem_wb_data | output | DATA_W | Written-back data |
| mem_wb_dirty | output | 1 | Written-back dirty flag |
| line_drop | output | 1 | Pulse: deallocate the array copy |
| loc_busy | output | 1 | Line in a flush state; local requests stall |
| loc_replay | output | 1 | Pulse: replay the parked local request |
| line_state | output | 4 | Current line state code |

## Verification
A wrong pending count shows up as a PUTF that arrives one or more cycles early or late, counted against the number of responses fed in. The sweep therefore checks the absence of PUTF after every non-final response and its presence on the idle cycle after the last one. A buffer that captured the wrong copy or dirty flag only shows up at the end, on `mem_wb_data`/`mem_wb_dirty`, or earlier on `peer_rsp_data` when a forwarded request is served. A wrong transition is visible on `line_state` on the very edge of the event that caused it. A lost parked request appears as a missing `loc_replay` pulse one cycle after the line returns to Invalid.

// File: rtl/flc_pkg.sv
package flc_pkg;

  // bit 3 set marks a flush transient state
  typedef enum logic [3:0] {
    ST_I    = 4'd0,
    ST_S    = 4'd1,
    ST_O    = 4'd2,
    ST_M    = 4'd3,
    ST_MM   = 4'd4,
    ST_IMF  = 4'd8,
    ST_SMF  = 4'd9,
    ST_OMF  = 4'd10,
    ST_ISMF = 4'd11,
    ST_MMF  = 4'd12,
    ST_MMWF = 4'd13,
    ST_MIF  = 4'd14
  } line_st_e;

  typedef enum logic [1:0] {LOP_LOAD = 2'd0, LOP_STORE = 2'd1, LOP_FLUSH = 2'd2} loc_op_e;

  typedef enum logic [2:0] {
    FW_GETX  = 3'd0,
    FW_GETS  = 3'd1,
    FW_MERGE = 3'd2,
    FW_INV   = 3'd3,
    FW_BLOCK = 3'd4,
    FW_WBACK = 3'd5
  } fwd_e;

  typedef enum logic [1:0] {RI_ACK = 2'd0, RI_DSH = 2'd1, RI_DEX = 2'd2} rsp_in_e;
  typedef enum logic [1:0] {PR_ACK = 2'd0, PR_DSH = 2'd1, PR_DEX = 2'd2} peer_rsp_e;
  typedef enum logic {DR_GETF = 1'b0, DR_PUTF = 1'b1} dir_req_e;
  typedef enum logic [1:0] {CO_HOLD, CO_LOAD, CO_INC, CO_DEC} cnt_op_e;
  typedef enum logic [2:0] {BO_HOLD, BO_CLEAR, BO_LOAD, BO_FILL, BO_MERGE} buf_op_e;

endpackage

// File: rtl/flc_pend_ctr.sv
module flc_pend_ctr
  import flc_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  localparam int CW = $clog2(NUM_CACHES + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  cnt_op_e       op,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          zero
);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else begin
      case (op)
        CO_LOAD: cnt <= load_val;
        CO_INC:  cnt <= cnt + 1'b1;
        CO_DEC:  cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign zero = (cnt == '0);

  // R4: a response is never counted past zero
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (op == CO_DEC) |-> (cnt != '0));

  // R9: raising the count never wraps it
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (op == CO_INC) |-> (cnt != '1));

endmodule

// File: rtl/flc_line_buf.sv
module flc_line_buf
  import flc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  buf_op_e           op,
  input  logic              set_sharer,
  input  logic [DATA_W-1:0] line_data,
  input  logic              line_dirty,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_dirty,
  output logic [DATA_W-1:0] data,
  output logic              dirty,
  output logic              sharer
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data   <= '0;
      dirty  <= 1'b0;
      sharer <= 1'b0;
    end else begin
      case (op)
        BO_CLEAR: begin data <= '0; dirty <= 1'b0; end
        BO_LOAD:  begin data <= line_data; dirty <= line_dirty; end
        BO_FILL:  begin data <= rsp_data; dirty <= rsp_dirty; end
        BO_MERGE: begin data <= rsp_data; dirty <= dirty | rsp_dirty; end
        default:  begin data <= data; dirty <= dirty; end
      endcase
      if (op == BO_CLEAR || op == BO_LOAD) sharer <= 1'b0;
      else if (set_sharer)                 sharer <= 1'b1;
    end
  end

  // R6: a fresh allocation starts with no sharer recorded
  a_r6_alloc_clears_sharer: assert property (@(posedge clk) disable iff (rst)
    (op == BO_CLEAR || op == BO_LOAD) |=> !sharer);

  // R5: a merge never clears an already dirty buffer
  a_r5_merge_keeps_dirty: assert property (@(posedge clk) disable iff (rst)
    (op == BO_MERGE && dirty) |=> dirty);

endmodule

// File: rtl/flc_replay.sv
module flc_replay (
  input  logic clk,
  input  logic rst,
  input  logic stall_hit,
  input  logic stable,
  output logic replay
);

  logic pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      replay  <= 1'b0;
    end else if (pending && stable) begin
      pending <= 1'b0;
      replay  <= 1'b1;
    end else begin
      replay <= 1'b0;
      if (stall_hit) pending <= 1'b1;
    end
  end

  // R10: a replay is only released after the line was stable
  a_r10_replay_when_stable: assert property (@(posedge clk) disable iff (rst)
    replay |-> $past(stable));

  // R10: a replay is a single-cycle pulse
  a_r10_replay_pulse: assert property (@(posedge clk) disable iff (rst)
    replay |=> !replay);

endmodule

// File: rtl/flush_line_ctrl.sv
module flush_line_ctrl
  import flc_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int DATA_W     = 32,
  localparam int CW = $clog2(NUM_CACHES + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loc_valid,
  input  logic [1:0]        loc_op,
  input  logic [DATA_W-1:0] line_data,
  input  logic              line_dirty,
  input  logic              fill_valid,
  input  logic [2:0]        fill_state,
  input  logic              fwd_valid,
  input  logic [2:0]        fwd_kind,
  input  logic              rsp_valid,
  input  logic [1:0]        rsp_kind,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_dirty,
  input  logic              rsp_shared,
  output logic              dir_req_valid,
  output logic              dir_req_kind,
  output logic              peer_rsp_valid,
  output logic [1:0]        peer_rsp_kind,
  output logic [DATA_W-1:0] peer_rsp_data,
  output logic              peer_rsp_dirty,
  output logic              mem_wb_valid,
  output logic [DATA_W-1:0] mem_wb_data,
  output logic              mem_wb_dirty,
  output logic              line_drop,
  output logic              loc_busy,
  output logic              loc_replay,
  output logic [3:0]        line_state
);

  localparam logic [CW-1:0] CNT_FULL  = CW'(NUM_CACHES);
  localparam logic [CW-1:0] CNT_OWNER = CW'(NUM_CACHES - 1);

  line_st_e          st, nxt;
  cnt_op_e           cop;
  logic [CW-1:0]     cval;
  logic [CW-1:0]     pend_cnt;
  logic              pend_zero;
  buf_op_e           bop;
  logic [DATA_W-1:0] buf_data;
  logic              buf_dirty, buf_sharer;
  logic              stable, set_sh;
  logic              req_v, wb_v, drop, pr_v;
  dir_req_e          req_k;
  peer_rsp_e         pr_k;
  loc_op_e           lop;
  fwd_e              fk;
  rsp_in_e           rk;

  assign lop    = loc_op_e'(loc_op);
  assign fk     = fwd_e'(fwd_kind);
  assign rk     = rsp_in_e'(rsp_kind);
  assign stable = !st[3];
  assign set_sh = !stable && rsp_valid && (rk == RI_ACK) && rsp_shared;

  flc_pend_ctr #(.NUM_CACHES(NUM_CACHES)) u_ctr (
    .clk(clk), .rst(rst), .op(cop), .load_val(cval),
    .cnt(pend_cnt), .zero(pend_zero)
  );

  flc_line_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .op(bop), .set_sharer(set_sh),
    .line_data(line_data), .line_dirty(line_dirty),
    .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
    .data(buf_data), .dirty(buf_dirty), .sharer(buf_sharer)
  );

  flc_replay u_rpl (
    .clk(clk), .rst(rst), .stall_hit(loc_valid && !stable),
    .stable(stable), .replay(loc_replay)
  );

  always_comb begin
    nxt   = st;
    cop   = CO_HOLD;
    cval  = CNT_FULL;
    bop   = BO_HOLD;
    req_v = 1'b0;
    req_k = DR_GETF;
    pr_v  = 1'b0;
    pr_k  = PR_ACK;
    wb_v  = 1'b0;
    drop  = 1'b0;
    if (stable) begin
      if (loc_valid && lop == LOP_FLUSH) begin
        req_v = 1'b1;
        cop   = CO_LOAD;
        case (st)
          ST_I:    begin nxt = ST_IMF; bop = BO_CLEAR; end
          ST_S:    begin nxt = ST_SMF; bop = BO_LOAD; drop = 1'b1; end
          ST_O:    begin nxt = ST_OMF; bop = BO_LOAD; drop = 1'b1; cval = CNT_OWNER; end
          default: begin nxt = ST_MMF; bop = BO_LOAD; drop = 1'b1; cval = CNT_OWNER; end
        endcase
      end else if (fill_valid && fill_state <= 3'd4) begin
        nxt = line_st_e'({1'b0, fill_state});
      end
    end else if (fwd_valid) begin
      case (st)
        ST_IMF: begin
          if (fk == FW_GETX || fk == FW_GETS || fk == FW_INV) pr_v = 1'b1;
        end
        ST_SMF: begin
          if (fk == FW_GETX || fk == FW_INV) begin pr_v = 1'b1; nxt = ST_IMF; end
          else if (fk == FW_GETS) pr_v = 1'b1;
        end
        ST_OMF: begin
          if (fk == FW_GETX || fk == FW_INV) begin
            pr_v = 1'b1; pr_k = PR_DEX; cop = CO_INC; nxt = ST_IMF;
          end else if (fk == FW_GETS || fk == FW_MERGE) begin
            pr_v = 1'b1; pr_k = PR_DSH;
          end
        end
        ST_MMF: begin
          if (fk == FW_GETX || fk == FW_INV || fk == FW_GETS) begin
            pr_v = 1'b1; pr_k = PR_DEX; cop = CO_INC; nxt = ST_IMF;
          end else if (fk == FW_MERGE) begin
            pr_v = 1'b1; pr_k = PR_DSH; nxt = ST_OMF;
          end else if (fk == FW_BLOCK) begin
            req_v = 1'b1; req_k = DR_PUTF; nxt = ST_MIF;
          end
        end
        ST_MIF: begin
          if (fk == FW_WBACK) begin wb_v = 1'b1; bop = BO_CLEAR; nxt = ST_I; end
        end
        default: ;
      endcase
    end else if (rsp_valid) begin
      if (st != ST_MIF && rk == RI_ACK) cop = CO_DEC;
      else if (rk == RI_DSH || rk == RI_DEX) begin
        if (st == ST_IMF) begin
          cop = CO_DEC; bop = BO_FILL;
          nxt = (rk == RI_DSH) ? ST_ISMF : ST_MMWF;
        end else if (st == ST_SMF) begin
          cop = CO_DEC; bop = BO_MERGE; nxt = ST_ISMF;
        end
      end
    end else if (pend_zero) begin
      case (st)
        ST_OMF, ST_MMF: begin req_v = 1'b1; req_k = DR_PUTF; nxt = ST_MIF; end
        ST_ISMF, ST_MMWF: begin
          if (!buf_sharer) begin req_v = 1'b1; req_k = DR_PUTF; nxt = ST_MIF; end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_I;
      dir_req_valid  <= 1'b0;
      dir_req_kind   <= 1'b0;
      peer_rsp_valid <= 1'b0;
      peer_rsp_kind  <= 2'd0;
      peer_rsp_data  <= '0;
      peer_rsp_dirty <= 1'b0;
      mem_wb_valid   <= 1'b0;
      mem_wb_data    <= '0;
      mem_wb_dirty   <= 1'b0;
      line_drop      <= 1'b0;
    end else begin
      st             <= nxt;
      dir_req_valid  <= req_v;
      dir_req_kind   <= req_k;
      peer_rsp_valid <= pr_v;
      peer_rsp_kind  <= pr_k;
      peer_rsp_data  <= buf_data;
      peer_rsp_dirty <= buf_dirty;
      mem_wb_valid   <= wb_v;
      mem_wb_data    <= buf_data;
      mem_wb_dirty   <= buf_dirty;
      line_drop      <= drop;
    end
  end

  assign loc_busy   = st[3];
  assign line_state = st;

  // R4: GETF leaves one of the two legal initial counts
  a_r4_getf_count: assert property (@(posedge clk) disable iff (rst)
    (dir_req_valid && dir_req_kind == DR_GETF) |->
      (pend_cnt == CNT_FULL || pend_cnt == CNT_OWNER));

  // R6: a PUTF always coincides with the write-back-wait state
  a_r6_putf_state: assert property (@(posedge clk) disable iff (rst)
    (dir_req_valid && dir_req_kind == DR_PUTF) |-> (st == ST_MIF));

  // R8: memory write-back only on leaving write-back-wait for Invalid
  a_r8_wb_to_invalid: assert property (@(posedge clk) disable iff (rst)
    mem_wb_valid |-> (st == ST_I && $past(st) == ST_MIF));

  // R3: the array copy is only dropped from a valid stable state
  a_r3_drop_source: assert property (@(posedge clk) disable iff (rst)
    line_drop |-> ($past(st) inside {ST_S, ST_O, ST_M, ST_MM}));

  // R9: handing exclusive data to a peer raises the count by one
  a_r9_dex_count: assert property (@(posedge clk) disable iff (rst)
    (peer_rsp_valid && peer_rsp_kind == PR_DEX) |->
      (pend_cnt == CW'($past(pend_cnt) + 1'b1)));

endmodule

// File: tb/flush_line_ctrl_test.sv
module flush_line_ctrl_test;
  localparam int N  = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loc_valid = 0; logic [1:0] loc_op = 0;
  logic [DW-1:0] line_data = 0; logic line_dirty = 0;
  logic fill_valid = 0; logic [2:0] fill_state = 0;
  logic fwd_valid = 0; logic [2:0] fwd_kind = 0;
  logic rsp_valid = 0; logic [1:0] rsp_kind = 0;
  logic [DW-1:0] rsp_data = 0; logic rsp_dirty = 0, rsp_shared = 0;
  logic dir_req_valid, dir_req_kind, peer_rsp_valid, peer_rsp_dirty;
  logic [1:0] peer_rsp_kind;
  logic [DW-1:0] peer_rsp_data, mem_wb_data;
  logic mem_wb_valid, mem_wb_dirty, line_drop, loc_busy, loc_replay;
  logic [3:0] line_state;

  int checks = 0;
  int fails  = 0;

  flush_line_ctrl #(.NUM_CACHES(N), .DATA_W(DW)) uut (.*);

  always #5 clk = ~clk;

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic idle(); tick(); endtask

  task automatic do_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
  endtask

  task automatic do_loc(int op);
    loc_valid = 1'b1; loc_op = 2'(op); tick(); loc_valid = 1'b0;
  endtask

  task automatic do_fill(int s);
    fill_valid = 1'b1; fill_state = 3'(s); tick(); fill_valid = 1'b0;
  endtask

  task automatic do_fwd(int k);
    fwd_valid = 1'b1; fwd_kind = 3'(k); tick(); fwd_valid = 1'b0;
  endtask

  task automatic do_rsp(int k, logic [DW-1:0] d, logic dy, logic sh);
    rsp_valid = 1'b1; rsp_kind = 2'(k); rsp_data = d; rsp_dirty = dy; rsp_shared = sh;
    tick(); rsp_valid = 1'b0; rsp_shared = 1'b0;
  endtask

  // Full flush from a given stable state, ack path, with a parked load
  task automatic flush_flow(int s, logic [DW-1:0] d, logic dy);
    int c0, tst;
    logic [DW-1:0] exp_d;
    logic exp_dy;
    if (s != 0) begin
      do_fill(s);
      chk("R11 fill", line_state, s);
    end
    line_data = d; line_dirty = dy;
    do_loc(2);
    tst = (s == 0) ? 8 : (s == 1) ? 9 : (s == 2) ? 10 : 12;
    chk("R2/R3 flush state", line_state, tst);
    chk("R2/R3 GETF valid", dir_req_valid, 1);
    chk("R2/R3 GETF kind", dir_req_kind, 0);
    chk("R2/R3 drop", line_drop, (s != 0));
    do_loc(0);
    chk("R10 busy", loc_busy, 1);
    chk("R10 load parked state", line_state, tst);
    c0 = (s <= 1) ? N : N - 1;
    if (s <= 1) begin
      for (int i = 0; i < c0 - 1; i++) begin
        do_rsp(0, '0, 0, 0); idle();
        chk("R4 no early PUTF", dir_req_valid, 0);
        chk("R4 state held", line_state, tst);
      end
      if (s == 0) begin
        do_rsp(2, d ^ 16'h5a5a, 1'b1, 0);
        chk("R5 excl data", line_state, 13);
        exp_d = d ^ 16'h5a5a; exp_dy = 1'b1;
      end else begin
        do_rsp(1, d, 1'b1, 0);
        chk("R5 shared data", line_state, 11);
        exp_d = d; exp_dy = 1'b1;
      end
    end else begin
      for (int i = 0; i < c0; i++) begin
        do_rsp(0, '0, 0, 0);
        chk("R4 no early PUTF", dir_req_valid, 0);
        chk("R4 state held", line_state, tst);
      end
      exp_d = d; exp_dy = dy;
    end
    idle();
    chk("R6 PUTF valid", dir_req_valid, 1);
    chk("R6 PUTF kind", dir_req_kind, 1);
    chk("R6 wait state", line_state, 14);
    do_fwd(5);
    chk("R8 wb valid", mem_wb_valid, 1);
    chk("R8 wb data", mem_wb_data, exp_d);
    chk("R8 wb dirty", mem_wb_dirty, exp_dy);
    chk("R8 invalid", line_state, 0);
    idle();
    chk("R10 replay", loc_replay, 1);
    chk("R10 not busy", loc_busy, 0);
    idle();
    chk("R10 replay once", loc_replay, 0);
  endtask

  initial begin
    do_reset();
    chk("R1 state", line_state, 0);
    chk("R1 dir", dir_req_valid, 0);
    chk("R1 peer", peer_rsp_valid, 0);
    chk("R1 wb", mem_wb_valid, 0);
    chk("R1 drop", line_drop, 0);
    chk("R1 busy", loc_busy, 0);
    chk("R1 replay", loc_replay, 0);

    for (int s = 0; s < 5; s++)
      for (int dy = 0; dy < 2; dy++)
        flush_flow(s, 16'(16'h1357 * (s + 1) + dy * 16'h0f0f), 1'(dy));

    // R6: a shared ack holds ISM-style completion; R11: fill ignored while busy
    do_reset();
    do_loc(2);
    do_fill(2);
    chk("R11 fill ignored", line_state, 8);
    do_rsp(0, '0, 0, 1);
    for (int i = 0; i < N - 2; i++) do_rsp(0, '0, 0, 0);
    do_rsp(2, 16'hbeef, 1, 0);
    chk("R5 excl data", line_state, 13);
    for (int i = 0; i < 3; i++) begin
      idle();
      chk("R6 sharer hold no PUTF", dir_req_valid, 0);
      chk("R6 sharer hold state", line_state, 13);
    end
    do_reset();

    // R7: block ack path
    do_fill(3);
    line_data = 16'hc0de; line_dirty = 1;
    do_loc(2);
    do_fwd(4);
    chk("R7 PUTF valid", dir_req_valid, 1);
    chk("R7 PUTF kind", dir_req_kind, 1);
    chk("R7 state", line_state, 14);
    do_fwd(5);
    chk("R8 wb data", mem_wb_data, 16'hc0de);
    chk("R8 wb dirty", mem_wb_dirty, 1);
    idle();
    chk("R10 no spurious replay", loc_replay, 0);

    // R9: exclusive request in MM_F
    do_fill(4);
    line_data = 16'h4242; line_dirty = 0;
    do_loc(2);
    do_fwd(0);
    chk("R9 peer valid", peer_rsp_valid, 1);
    chk("R9 peer kind", peer_rsp_kind, 2);
    chk("R9 peer data", peer_rsp_data, 16'h4242);
    chk("R9 to IM_F", line_state, 8);
    for (int i = 0; i < N - 1; i++) begin
      do_rsp(0, '0, 0, 0); idle();
      chk("R4 recount no PUTF", dir_req_valid, 0);
    end
    do_rsp(1, 16'h7777, 0, 0);
    chk("R5 shared data", line_state, 11);
    idle();
    chk("R4 recount PUTF", dir_req_valid, 1);
    do_fwd(5);
    chk("R8 wb data", mem_wb_data, 16'h7777);

    // R9: invalidate in SM_F, then shared request in IM_F
    do_fill(1);
    do_loc(2);
    do_fwd(1);
    chk("R12 SM_F shared ack", peer_rsp_kind, 0);
    chk("R12 SM_F state", line_state, 9);
    do_fwd(3);
    chk("R9 SM_F ack valid", peer_rsp_valid, 1);
    chk("R9 SM_F ack kind", peer_rsp_kind, 0);
    chk("R9 SM_F to IM_F", line_state, 8);
    do_fwd(1);
    chk("R9 IM_F ack valid", peer_rsp_valid, 1);
    chk("R9 IM_F ack kind", peer_rsp_kind, 0);
    chk("R9 IM_F state", line_state, 8);
    do_reset();

    // R12: merged in MM_F to OM_F, shared request in OM_F
    do_fill(3);
    line_data = 16'h9a9a; line_dirty = 1;
    do_loc(2);
    do_fwd(2);
    chk("R12 merged kind", peer_rsp_kind, 1);
    chk("R12 merged data", peer_rsp_data, 16'h9a9a);
    chk("R12 to OM_F", line_state, 10);
    do_fwd(1);
    chk("R12 OM_F shared valid", peer_rsp_valid, 1);
    chk("R12 OM_F shared kind", peer_rsp_kind, 1);
    chk("R12 OM_F state", line_state, 10);
    for (int i = 0; i < N - 1; i++) do_rsp(0, '0, 0, 0);
    idle();
    chk("R6 OM_F PUTF", dir_req_valid, 1);
    chk("R6 OM_F wait", line_state, 14);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule